// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of an 8-bit successive-approximation converter with eight multiplexed analog inputs. Software talks to it over a narrow 4-bit register bus. It writes a channel register and a start register, and it reads a status register and a result register. The block drives the input multiplexer, a sample window and an 8-bit trial code toward an external ladder and comparator. It takes back one comparator decision per step and builds the result MSB first.

Time is counted in instruction cycles, which arrive as single-clock pulses on `tick`. A conversion spends 2 ticks sampling and then 2 ticks on each result bit, from the MSB down. It finishes on the 24th tick after the start, which sets the done flag. The flag drops when a new conversion starts, or once software has read both result nibbles in either order. A low-power hold request has priority over everything else:
- A hold that arrives mid-conversion abandons the conversion, and the flag stays clear.
- A hold that arrives after completion leaves the result and the flag intact.
- While hold is asserted, the bus has no effect on the block.

The sequencer has five states:
- `ST_IDLE`: waiting.
- `ST_SAMPLE`: sample window open.
- `ST_BITSTEP`: one trial bit on the comparator.
- `ST_TAIL`: settle ticks after the LSB.
- `ST_HALT`: hold asserted.

Its transitions:
- Any state goes to `ST_HALT` on hold.
- Any state goes to `ST_SAMPLE` on an accepted start.
- `ST_SAMPLE` goes to `ST_BITSTEP` after 2 ticks.
- `ST_BITSTEP` stays in `ST_BITSTEP` after each 2-tick step until the LSB step is done, then goes to `ST_TAIL`.
- `ST_TAIL` goes to `ST_IDLE`, raising the done flag, when the 24th tick is reached.
- `ST_HALT` goes to `ST_IDLE` when hold drops.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset the done flag is 0, the sample window is closed, the trial code is 0, and the channel register holds 0, so `mux_en`=1 and `mux_ch`=0.
- R2: A write with `wr_addr`=0 loads `wr_data` into the channel register on that clock edge. For the values 0 to 7, `mux_en` becomes 1 and `mux_ch` becomes the value. Any value with bit 3 set gives `mux_en`=0.
- R3: A write with `wr_addr`=1 and `wr_data[0]`=1 starts a conversion. `sample_en` is high from the next cycle for exactly 2 ticks. The start is one-shot: no further conversion begins without a new write. A write with `wr_data[0]`=0 starts nothing.
- R4: Bits are decided MSB first, 2 ticks each. The trial code is the bits kept so far plus the bit under test. A bit is kept when `cmp_ge`=1. With an ideal comparator, the result equals the input code.
- R5: The done flag rises on the clock edge of the 24th tick after the accepted start, and at no other time.
- R6: An accepted start clears the done flag on that edge.
- R7: With the flag set, the flag clears on the edge that completes reads of both result nibbles, in either order. Reading only one nibble, or the status register, leaves it set.
- R8: A read with `rd_addr`=0 returns the flag in bit 0 and zeros above it. A read with `rd_addr`=1 returns result bits 3:0 when `nib_hi`=0 and bits 7:4 when `nib_hi`=1.
- R9: A start during a conversion abandons it, and a new conversion begins at once, completing 24 ticks after the restart with a correct result.
- R10: Hold asserted during a conversion ends it. The sample window closes, and the flag stays 0 during and after the hold.
- R11: Hold asserted after the flag is set keeps both the flag and the result.
- R12: While hold is asserted, register writes and result reads have no effect: no start, no channel change, no flag clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock pulse per instruction cycle |
| hold_req | input | 1 | Low-power hold request, level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = channel register, 1 = start register |
| wr_data | input | 4 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 = status, 1 = result |
| nib_hi | input | 1 | Result nibble select: 0 low, 1 high |
| rd_data | output | 4 | Read data |
| mux_en | output | 1 | An input channel is selected |
| mux_ch | output | 3 | Selected input channel |
| sample_en | output | 1 | Sample window open |
| trial_code | output | 8 | Code applied to the reference ladder |
| cmp_ge | input | 1 | Comparator: input at or above trial level |
| eoc_flag | output | 1 | Conversion-done flag |

## Verification
The assertions are checked on every cycle and cover these points:
- a sample window opens only after an accepted start write;
- the trial code is zero while sampling, and the flag is low during the window;
- the flag rises only on a tick edge with hold low;
- a channel write reaches the mux pins one cycle later;
- hold closes the window and freezes the flag and the mux.

Only the bench scenarios can show the following, by comparing against a tick-counting reference model:
- exact 24-tick completion after a start or restart;
- correct results across input codes, including 0 and 255;
- flag clearing after both nibble reads in either order;
- a hold that arrives mid-conversion versus one that arrives after completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_BITSTEP,
        ST_TAIL,
        ST_HALT
    } seq_state_e;

    // register bus addresses
    localparam logic WA_CHAN   = 1'b0;
    localparam logic WA_START  = 1'b1;
    localparam logic RA_STATUS = 1'b0;
    localparam logic RA_RESULT = 1'b1;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_TICKS = 2,
    parameter int BIT_TICKS    = 2,
    parameter int TAIL_TICKS   = 6,
    parameter int CNT_W        = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold_req,
    input  logic start_req,
    input  logic last_bit,
    output logic sar_clr,
    output logic sar_step,
    output logic conv_done,
    output logic sample_en,
    output logic bit_active
);

    localparam logic [CNT_W-1:0] SAMPLE_END = CNT_W'(SAMPLE_TICKS - 1);
    localparam logic [CNT_W-1:0] BIT_END    = CNT_W'(BIT_TICKS - 1);
    localparam logic [CNT_W-1:0] TAIL_END   = CNT_W'(TAIL_TICKS - 1);

    seq_state_e       state_q, state_nx;
    logic [CNT_W-1:0] tcnt_q, tcnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_nx;
            tcnt_q  <= tcnt_nx;
        end
    end

    // transitions and strobes
    always_comb begin
        state_nx  = state_q;
        tcnt_nx   = tcnt_q;
        sar_clr   = 1'b0;
        sar_step  = 1'b0;
        conv_done = 1'b0;
        if (hold_req) begin
            state_nx = ST_HALT;
            tcnt_nx  = '0;
        end else if (start_req) begin
            state_nx = ST_SAMPLE;
            tcnt_nx  = '0;
            sar_clr  = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_nx = ST_IDLE;
                end
                ST_HALT: begin
                    state_nx = ST_IDLE;
                end
                ST_SAMPLE: begin
                    if (tick) begin
                        if (tcnt_q == SAMPLE_END) begin
                            state_nx = ST_BITSTEP;
                            tcnt_nx  = '0;
                        end else begin
                            tcnt_nx = tcnt_q + 1'b1;
                        end
                    end
                end
                ST_BITSTEP: begin
                    if (tick) begin
                        if (tcnt_q == BIT_END) begin
                            sar_step = 1'b1;
                            tcnt_nx  = '0;
                            if (last_bit) state_nx = ST_TAIL;
                        end else begin
                            tcnt_nx = tcnt_q + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        if (tcnt_q == TAIL_END) begin
                            state_nx  = ST_IDLE;
                            tcnt_nx   = '0;
                            conv_done = 1'b1;
                        end else begin
                            tcnt_nx = tcnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                    tcnt_nx  = '0;
                end
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        sample_en  = (state_q == ST_SAMPLE);
        bit_active = (state_q == ST_BITSTEP);
    end

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             active,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] res,
    output logic [RES_W-1:0] trial,
    output logic             last_bit
);

    localparam int BP_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [BP_W-1:0] MSB_POS = BP_W'(RES_W - 1);

    logic [BP_W-1:0]  bitpos_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] probe;

    assign probe = RES_W'(1) << bitpos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q    <= '0;
            bitpos_q <= MSB_POS;
        end else if (clr) begin
            res_q    <= '0;
            bitpos_q <= MSB_POS;
        end else if (step) begin
            // keep the bit under test when the input reaches the trial level
            res_q    <= cmp_ge ? (res_q | probe) : res_q;
            bitpos_q <= bitpos_q - 1'b1;
        end
    end

    assign res      = res_q;
    assign trial    = active ? (res_q | probe) : res_q;
    assign last_bit = (bitpos_q == '0);

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int BUS_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_req,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               rd_en,
    input  logic               rd_addr,
    input  logic               nib_hi,
    input  logic [2*BUS_W-1:0] res,
    input  logic               conv_done,
    output logic               start_req,
    output logic [BUS_W-1:0]   chan_q,
    output logic               eoc_flag,
    output logic [BUS_W-1:0]   rd_data
);

    logic flag_q, seen_lo_q, seen_hi_q;
    logic res_hit, both_read;

    assign start_req = wr_en && !hold_req && (wr_addr == WA_START) && wr_data[0];
    assign res_hit   = rd_en && !hold_req && (rd_addr == RA_RESULT) && flag_q;
    assign both_read = (seen_lo_q || !nib_hi) && (seen_hi_q || nib_hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (wr_en && !hold_req && (wr_addr == WA_CHAN)) begin
            chan_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q    <= 1'b0;
            seen_lo_q <= 1'b0;
            seen_hi_q <= 1'b0;
        end else if (start_req) begin
            flag_q    <= 1'b0;
            seen_lo_q <= 1'b0;
            seen_hi_q <= 1'b0;
        end else if (conv_done) begin
            flag_q    <= 1'b1;
            seen_lo_q <= 1'b0;
            seen_hi_q <= 1'b0;
        end else if (res_hit) begin
            if (both_read) begin
                flag_q    <= 1'b0;
                seen_lo_q <= 1'b0;
                seen_hi_q <= 1'b0;
            end else begin
                seen_lo_q <= seen_lo_q || !nib_hi;
                seen_hi_q <= seen_hi_q || nib_hi;
            end
        end
    end

    assign eoc_flag = flag_q;

    always_comb begin
        if (rd_addr == RA_STATUS) begin
            rd_data = {{(BUS_W-1){1'b0}}, flag_q};
        end else if (nib_hi) begin
            rd_data = res[BUS_W +: BUS_W];
        end else begin
            rd_data = res[0 +: BUS_W];
        end
    end

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
    parameter int BUS_W        = 4,
    parameter int SAMPLE_TICKS = 2,
    parameter int BIT_TICKS    = 2,
    parameter int TOTAL_TICKS  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               hold_req,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               rd_en,
    input  logic               rd_addr,
    input  logic               nib_hi,
    output logic [BUS_W-1:0]   rd_data,
    output logic               mux_en,
    output logic [BUS_W-2:0]   mux_ch,
    output logic               sample_en,
    output logic [2*BUS_W-1:0] trial_code,
    input  logic               cmp_ge,
    output logic               eoc_flag
);

    localparam int RES_W      = 2 * BUS_W;
    localparam int TAIL_TICKS = TOTAL_TICKS - SAMPLE_TICKS - RES_W * BIT_TICKS;
    localparam int CNT_W      = $clog2(TOTAL_TICKS + 1);

    logic             start_req, last_bit;
    logic             sar_clr, sar_step, conv_done, bit_active;
    logic [RES_W-1:0] res;
    logic [BUS_W-1:0] chan_q;

    adc_seq_regs #(.BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .nib_hi    (nib_hi),
        .res       (res),
        .conv_done (conv_done),
        .start_req (start_req),
        .chan_q    (chan_q),
        .eoc_flag  (eoc_flag),
        .rd_data   (rd_data)
    );

    adc_seq_ctrl #(
        .SAMPLE_TICKS (SAMPLE_TICKS),
        .BIT_TICKS    (BIT_TICKS),
        .TAIL_TICKS   (TAIL_TICKS),
        .CNT_W        (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hold_req   (hold_req),
        .start_req  (start_req),
        .last_bit   (last_bit),
        .sar_clr    (sar_clr),
        .sar_step   (sar_step),
        .conv_done  (conv_done),
        .sample_en  (sample_en),
        .bit_active (bit_active)
    );

    adc_seq_sar #(.RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sar_clr),
        .step     (sar_step),
        .active   (bit_active),
        .cmp_ge   (cmp_ge),
        .res      (res),
        .trial    (trial_code),
        .last_bit (last_bit)
    );

    assign mux_en = !chan_q[BUS_W-1];
    assign mux_ch = chan_q[BUS_W-2:0];

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int BUS_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               hold_req,
    input logic               wr_en,
    input logic               wr_addr,
    input logic [BUS_W-1:0]   wr_data,
    input logic               mux_en,
    input logic [BUS_W-2:0]   mux_ch,
    input logic               sample_en,
    input logic [2*BUS_W-1:0] trial_code,
    input logic               eoc_flag
);

    // R2
    chan_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && !hold_req) |=>
            (mux_en == !$past(wr_data[BUS_W-1])) && (mux_ch == $past(wr_data[BUS_W-2:0])));

    // R3
    sample_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_en) |-> $past(wr_en && wr_addr && wr_data[0] && !hold_req));

    // R4
    sample_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (trial_code == '0));

    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_flag) |-> ($past(tick) && !$past(hold_req)));

    // R6
    flag_low_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> !eoc_flag);

    // R10
    hold_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> !sample_en);

    // R12
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> ($stable(eoc_flag) && $stable(mux_en) && $stable(mux_ch)));

endmodule

bind adc_sar_seq adc_seq_chk #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/sim_adc_sar_seq.sv
module sim_adc_sar_seq;

    // 250 MHz: 4-unit period with 1 ns units
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hold_req = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [3:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic       nib_hi = 1'b0;
    logic [3:0] rd_data;
    logic       mux_en;
    logic [2:0] mux_ch;
    logic       sample_en;
    logic [7:0] trial_code;
    logic       cmp_ge;
    logic       eoc_flag;

    int vin [8];
    int checks = 0;
    int errors = 0;
    int tick_total = 0;
    int tdiv = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;

    always #HALF clk = ~clk;

    adc_sar_seq u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold_req(hold_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .nib_hi(nib_hi), .rd_data(rd_data),
        .mux_en(mux_en), .mux_ch(mux_ch), .sample_en(sample_en),
        .trial_code(trial_code), .cmp_ge(cmp_ge), .eoc_flag(eoc_flag)
    );

    // ideal comparator on the selected input
    assign cmp_ge = mux_en ? (vin[mux_ch] >= int'(trial_code)) : 1'b0;

    // instruction-cycle pulse every third clock, driven off the edge
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 3;
        tick = (tdiv == 0);
    end

    always @(posedge clk) if (tick) tick_total++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_chan, m_conv, m_t, m_res, m_flag, m_lo, m_hi, m_valid;

    function automatic int m_trial();
        if (m_conv != 0 && m_t >= 2 && m_t < 18)
            return m_res | (1 << (7 - (m_t - 2) / 2));
        return m_res;
    endfunction

    always @(posedge clk) begin
        int f0;
        int tr;
        if (!rst_n) begin
            m_chan = 0; m_conv = 0; m_t = 0; m_res = 0;
            m_flag = 0; m_lo = 0; m_hi = 0; m_valid = 1;
        end else if (hold_req) begin
            if (m_conv != 0) begin
                m_conv = 0;
                m_valid = 0;
            end
        end else begin
            f0 = m_flag;
            if (wr_en && wr_addr && wr_data[0]) begin
                m_conv = 1; m_t = 0; m_res = 0; m_flag = 0;
                m_lo = 0; m_hi = 0; m_valid = 1;
            end else begin
                if (m_conv != 0 && tick) begin
                    if (m_t >= 2 && m_t < 18 && ((m_t - 2) % 2) == 1) begin
                        tr = m_trial();
                        if (vin[m_chan & 7] >= tr && m_chan < 8) m_res = tr;
                    end
                    m_t++;
                    if (m_t == 24) begin
                        m_conv = 0;
                        m_flag = 1;
                    end
                end
                if (rd_en && rd_addr && f0 != 0) begin
                    if (nib_hi) m_hi = 1; else m_lo = 1;
                    if (m_lo != 0 && m_hi != 0) begin
                        m_flag = 0; m_lo = 0; m_hi = 0;
                    end
                end
            end
            if (wr_en && !wr_addr) m_chan = int'(wr_data);
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int exp_rd;
        if (rst_n && model_on && !finished) begin
            chk(eoc_flag == m_flag[0], "R5 flag", eoc_flag, m_flag);
            chk(sample_en == (m_conv != 0 && m_t < 2), "R3 sample window",
                sample_en, (m_conv != 0 && m_t < 2));
            chk(mux_en == (m_chan < 8), "R2 mux_en", mux_en, (m_chan < 8));
            chk(int'(mux_ch) == (m_chan & 7), "R2 mux_ch", mux_ch, m_chan & 7);
            if (m_valid != 0)
                chk(int'(trial_code) == m_trial(), "R4 trial code", trial_code, m_trial());
            if (!rd_addr) begin
                chk(int'(rd_data) == m_flag, "R8 status read", rd_data, m_flag);
            end else if (m_valid != 0 && m_conv == 0) begin
                exp_rd = nib_hi ? ((m_res >> 4) & 15) : (m_res & 15);
                chk(int'(rd_data) == exp_rd, "R8 result read", rd_data, exp_rd);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic a, input logic hi, output int v);
        rd_en = 1'b1; rd_addr = a; nib_hi = hi;
        #1 v = int'(rd_data);
        step();
        rd_en = 1'b0; rd_addr = 1'b0; nib_hi = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        int s = tick_total;
        while (tick_total - s < n) step();
    endtask

    task automatic wait_flag();
        int n = 0;
        while (!eoc_flag && n < 400) begin
            step();
            n++;
        end
    endtask

    task automatic convert(input int ch, input string tag);
        int t0;
        int v;
        wr(1'b0, 4'(ch));
        wr(1'b1, 4'b0001);
        t0 = tick_total;
        wait_flag();
        chk(tick_total - t0 == 24, {tag, " R5 ticks to done"}, tick_total - t0, 24);
        rd(1'b0, 1'b0, v);
        chk(v == 1, {tag, " R8 status bit0"}, v, 1);
        rd(1'b1, 1'b0, v);
        chk(v == (vin[ch] & 15), {tag, " R4 low nibble"}, v, vin[ch] & 15);
        chk(eoc_flag == 1'b1, {tag, " R7 one nibble keeps flag"}, eoc_flag, 1);
        rd(1'b1, 1'b1, v);
        chk(v == (vin[ch] >> 4), {tag, " R4 high nibble"}, v, vin[ch] >> 4);
        chk(eoc_flag == 1'b0, {tag, " R7 both nibbles clear flag"}, eoc_flag, 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int v;
        int t0;
        vin[0] = 0;   vin[1] = 60;  vin[2] = 128; vin[3] = 165;
        vin[4] = 17;  vin[5] = 129; vin[6] = 127; vin[7] = 255;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        model_on = 1'b1;
        step();

        // R1 reset state
        chk(eoc_flag == 1'b0, "R1 flag", eoc_flag, 0);
        chk(sample_en == 1'b0, "R1 sample", sample_en, 0);
        chk(trial_code == 8'd0, "R1 trial", trial_code, 0);
        chk(mux_en == 1'b1 && mux_ch == 3'd0, "R1 mux", {mux_en, mux_ch}, 8);
        rd(1'b0, 1'b0, v);
        chk(v == 0, "R1 status", v, 0);

        // R4 several input codes, including both extremes
        convert(3, "ch3");
        convert(0, "ch0");
        convert(7, "ch7");
        convert(2, "ch2");
        convert(5, "ch5");

        // R7 reverse read order
        wr(1'b0, 4'd6);
        wr(1'b1, 4'b0001);
        wait_flag();
        rd(1'b1, 1'b1, v);
        chk(v == (vin[6] >> 4), "R7 high first value", v, vin[6] >> 4);
        rd(1'b0, 1'b0, v);
        chk(eoc_flag == 1'b1, "R7 status read keeps flag", eoc_flag, 1);
        rd(1'b1, 1'b0, v);
        chk(eoc_flag == 1'b0, "R7 reverse order clears", eoc_flag, 0);

        // R2 channel select outside 0..7
        wr(1'b0, 4'b1010);
        chk(mux_en == 1'b0, "R2 bit3 deselects", mux_en, 0);
        wr(1'b0, 4'd4);
        chk(mux_en == 1'b1 && mux_ch == 3'd4, "R2 channel 4", mux_ch, 4);

        // R3 start register with bit0 clear starts nothing
        wr(1'b1, 4'b1110);
        repeat (12) begin
            step();
            chk(sample_en == 1'b0, "R3 no start without bit0", sample_en, 0);
        end

        // R3 one-shot and R6 clear on start
        wr(1'b1, 4'b0001);
        wait_flag();
        repeat (80) step();
        chk(eoc_flag == 1'b1 && sample_en == 1'b0, "R3 one-shot", eoc_flag, 1);
        wr(1'b1, 4'b0001);
        chk(eoc_flag == 1'b0, "R6 start clears flag", eoc_flag, 1);
        wait_flag();

        // R9 restart mid-conversion
        wr(1'b0, 4'd1);
        wr(1'b1, 4'b0001);
        wait_ticks(11);
        wr(1'b1, 4'b0001);
        t0 = tick_total;
        wait_flag();
        chk(tick_total - t0 == 24, "R9 restart timing", tick_total - t0, 24);
        rd(1'b1, 1'b0, v);
        chk(v == (vin[1] & 15), "R9 restart low", v, vin[1] & 15);
        rd(1'b1, 1'b1, v);
        chk(v == (vin[1] >> 4), "R9 restart high", v, vin[1] >> 4);

        // R10 hold during conversion
        wr(1'b1, 4'b0001);
        wait_ticks(5);
        hold_req = 1'b1;
        repeat (12) step();
        chk(eoc_flag == 1'b0 && sample_en == 1'b0, "R10 during hold", eoc_flag, 0);
        hold_req = 1'b0;
        wait_ticks(40);
        chk(eoc_flag == 1'b0, "R10 flag stays clear after release", eoc_flag, 0);

        // R11 / R12 hold after completion
        convert(4, "ch4");
        wr(1'b0, 4'd3);
        wr(1'b1, 4'b0001);
        wait_flag();
        hold_req = 1'b1;
        step();
        wr(1'b1, 4'b0001);
        wr(1'b0, 4'd7);
        rd(1'b1, 1'b0, v);
        rd(1'b1, 1'b1, v);
        repeat (6) step();
        chk(eoc_flag == 1'b1, "R12 flag held during hold", eoc_flag, 1);
        chk(mux_ch == 3'd3, "R12 channel write ignored", mux_ch, 3);
        chk(sample_en == 1'b0, "R12 start ignored", sample_en, 0);
        hold_req = 1'b0;
        step();
        chk(eoc_flag == 1'b1, "R11 flag kept", eoc_flag, 1);
        rd(1'b1, 1'b0, v);
        chk(v == (vin[3] & 15), "R11 low kept", v, vin[3] & 15);
        rd(1'b1, 1'b1, v);
        chk(v == (vin[3] >> 4), "R11 high kept", v, vin[3] >> 4);
        chk(eoc_flag == 1'b0, "R7 reads after hold clear", eoc_flag, 0);

        step();
        finished = 1'b1;
        summary();
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) act=timeout exp=finish");
            summary();
            $finish;
        end
    end

endmodule